// File: doc/BRIEF.md
# At-Speed Scan Capture Clock Controller

This block drives the clock of one clock domain's scan flops. It sits after the domain's own divider. While scan data is being shifted, the slow tester clock reaches the domain. When the shift ends, the controller cuts the domain off from every source. It then lets through exactly two pulses of the domain's own functional clock: a launch pulse and a capture pulse. This gives transition-delay tests at the real operating rate without a separate scan clock multiplexer inside the IP. Outside test mode the functional clock passes through unchanged.

A design places one controller in each domain. Each domain therefore captures at its own rate, for example 400, 200 and 100 MHz, and no shared fast clock is used. A controller can start its burst in two ways. In local mode a capture trigger starts it. In aligned mode a strobe that is shared by all controllers is sampled on the slowest domain's clock, so that bursts in related domains start together and paths that cross between those domains are tested at speed. Both clock sources are gated by latches that are transparent only while their source clock is low. A change of source therefore never produces a shortened pulse.

Top module: `scan_clk_ctrl`

## Requirements
- R1: With `test_mode` low, `clk_out` equals `fclk`, with one rising edge per `fclk` rising edge.
- R2: With `test_mode` and `scan_en` high, `clk_out` has one rising edge per `tclk` pulse, and no `fclk` edge reaches it.
- R3: A falling `scan_en` passes through a two-flop synchronizer clocked by `fclk` before a burst can be armed. When the trigger is held high from the moment `scan_en` falls, the first capture pulse appears on the fifth `fclk` rising edge after the fall.
- R4: In local mode (`sync_mode` low), a `trig` level of 1 sampled on `fclk` rising edge k produces `clk_out` pulses on edges k+1 and k+2 only.
- R5: While reset is low, `clk_out` gives no pulse in test mode with `scan_en` low, and `burst_done` is 0.
- R6: After the second pulse, `clk_out` stays quiet and further `trig` or strobe activity has no effect until `scan_en` is raised again.
- R7: `burst_done` goes to 1 on the same `fclk` edge as the second pulse. It returns to 0 on the third `fclk` rising edge after `scan_en` rises.
- R8: In aligned mode (`sync_mode` high), `trig` is ignored. `sync_start` is captured on `sync_clk` rising edges. The burst pulses fall on the second and third `fclk` rising edges after the `sync_clk` edge that first captures `sync_start` high.
- R9: Every capture window with `scan_en` low yields exactly two pulses, whatever the shift length, the wait before the trigger and the mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Functional clock of the domain, taken after its divider |
| tclk | input | 1 | Slow tester shift clock |
| sync_clk | input | 1 | Clock of the slowest related domain, used to sample the shared strobe |
| rst_n | input | 1 | Synchronous active-low reset |
| test_mode | input | 1 | Selects the scan clocking paths; held static during a test |
| scan_en | input | 1 | High during shift; changed only while `tclk` is low |
| sync_mode | input | 1 | 1 = aligned start from `sync_start`, 0 = local start from `trig` |
| trig | input | 1 | Local capture trigger, sampled on `fclk` |
| sync_start | input | 1 | Start strobe shared by the controllers of related domains |
| clk_out | output | 1 | Gated clock sent to the domain's scan flops |
| burst_done | output | 1 | High after the second capture pulse, until shift resumes |

## Verification
The bench measures exactly when the first capture pulse appears after `scan_en` falls. A synchronizer that is one stage too short moves the pulse one edge early, and a missing stage lets the pulse start before the shift has settled. Every window is checked for exactly two pulses. An error in the counter limit gives one pulse or three, and a gate that is not latched lets extra functional edges through during shift. The bench also retriggers after the burst and toggles `trig` in aligned mode. A design that re-arms early or listens to the wrong start source then produces a second burst. Finally, the bench checks when `burst_done` rises and when it clears, because the count of pulses per window depends on that flag.

// File: rtl/scc_pkg.sv
`timescale 1ns/1ps
// Shared types for the scan clock controller.
package scc_pkg;
    // Burst sequencer phases, in the functional clock domain.
    typedef enum logic [1:0] {
        PH_SHIFT = 2'd0,   // scan shift, or waiting for the synchronized fall
        PH_ARMED = 2'd1,   // shift over, waiting for a start event
        PH_BURST = 2'd2,   // functional pulses are enabled
        PH_HOLD  = 2'd3    // burst finished, quiet until shift resumes
    } phase_t;
endpackage

// File: rtl/scc_sync.sv
`timescale 1ns/1ps
// Level synchronizer: carries an asynchronous level into the clk domain.
// Assumes STAGES >= 2. The reset value is set by a parameter.
module scc_sync #(
    parameter int   STAGES = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/scc_clk_gate.sv
`timescale 1ns/1ps
// Latch-based clock gate. The enable is captured only while clk is low,
// so the gated output never produces a shortened high phase.
// Assumes en settles during the low phase of clk.
module scc_clk_gate (
    input  logic clk,
    input  logic en,
    output logic gclk
);
    logic en_lat;

    // Transparent while the source clock is low.
    always_latch begin
        if (!clk) en_lat <= en;
    end

    assign gclk = clk & en_lat;
endmodule

// File: rtl/scc_burst_fsm.sv
`timescale 1ns/1ps
// Burst sequencer in the functional clock domain. It arms after the
// synchronized end of shift, starts on a local trigger or on a rising
// shared strobe, enables the gate for BURST_LEN cycles, and then holds
// until shift resumes. Assumes the strobe level is synchronous to clk.
module scc_burst_fsm
    import scc_pkg::*;
#(
    parameter int BURST_LEN = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic se_sync,
    input  logic sync_mode,
    input  logic trig,
    input  logic strobe_lvl,
    output logic gate_en,
    output logic done
);
    localparam int CW = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
    localparam logic [CW-1:0] LAST = CW'(BURST_LEN - 1);

    phase_t        ph;
    logic [CW-1:0] cnt;
    logic          strobe_d;
    logic          strobe_rise;
    logic          go;

    // Keep the previous strobe level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_d <= 1'b0;
        else        strobe_d <= strobe_lvl;
    end

    assign strobe_rise = strobe_lvl & ~strobe_d;
    assign go          = sync_mode ? strobe_rise : trig;

    // Phase sequencing and pulse counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph  <= PH_SHIFT;
            cnt <= '0;
        end else begin
            case (ph)
                PH_SHIFT: if (!se_sync) ph <= PH_ARMED;
                PH_ARMED: begin
                    if (se_sync) ph <= PH_SHIFT;
                    else if (go) begin
                        ph  <= PH_BURST;
                        cnt <= '0;
                    end
                end
                PH_BURST: begin
                    if (cnt == LAST) ph <= PH_HOLD;
                    else             cnt <= cnt + 1'b1;
                end
                PH_HOLD:  if (se_sync) ph <= PH_SHIFT;
                default:  ph <= PH_SHIFT;
            endcase
        end
    end

    assign gate_en = (ph == PH_BURST);
    assign done    = (ph == PH_HOLD);

    // R4: the burst lasts exactly BURST_LEN cycles and then holds.
    assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_BURST && cnt == LAST) |=> (ph == PH_HOLD));
    // R3: a burst only starts from the armed phase with shift synced low.
    assert_arm_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate_en) |-> ($past(ph) == PH_ARMED && !$past(se_sync)));
    // R6: the hold phase is left only when shift resumes.
    assert_hold_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_HOLD && !se_sync) |=> (done && !gate_en));
    // R7: done clears one edge after the synchronized shift level returns.
    assert_done_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && se_sync) |=> !done);
    // R8: in aligned mode only a strobe rise can start a burst.
    assert_align_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_ARMED && sync_mode && !strobe_rise) |=> !gate_en);
endmodule

// File: rtl/scan_clk_ctrl.sv
`timescale 1ns/1ps
// Scan clock controller for one clock domain. It passes tclk during shift,
// a BURST_LEN-pulse burst of fclk for capture, and fclk outside test mode.
// Assumes test_mode is static, scan_en changes only while tclk is low,
// and sync_clk is derived from the same source as fclk.
module scan_clk_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int BURST_LEN   = 2
) (
    input  logic fclk,
    input  logic tclk,
    input  logic sync_clk,
    input  logic rst_n,
    input  logic test_mode,
    input  logic scan_en,
    input  logic sync_mode,
    input  logic trig,
    input  logic sync_start,
    output logic clk_out,
    output logic burst_done
);
    logic se_sync;
    logic strobe_q;
    logic f_en;
    logic t_en;
    logic f_gclk;
    logic t_gclk;

    scc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_se_sync (
        .clk(fclk), .rst_n(rst_n), .d(scan_en), .q(se_sync)
    );

    // Sample the shared start strobe on the slowest domain's clock.
    always_ff @(posedge sync_clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= sync_start;
    end

    scc_burst_fsm #(.BURST_LEN(BURST_LEN)) u_fsm (
        .clk(fclk), .rst_n(rst_n), .se_sync(se_sync), .sync_mode(sync_mode),
        .trig(trig), .strobe_lvl(strobe_q), .gate_en(f_en), .done(burst_done)
    );

    assign t_en = scan_en & test_mode;

    scc_clk_gate u_fgate (.clk(fclk), .en(f_en), .gclk(f_gclk));
    scc_clk_gate u_tgate (.clk(tclk), .en(t_en), .gclk(t_gclk));

    assign clk_out = test_mode ? (f_gclk | t_gclk) : fclk;
endmodule

// File: tb/sim_scan_clk_ctrl.sv
`timescale 1ns/1ps
module sim_scan_clk_ctrl;
    logic fclk = 0, tclk = 0, sync_clk = 0, rst_n = 0;
    logic test_mode = 0, scan_en = 0, sync_mode = 0, trig = 0, sync_start = 0;
    logic clk_out, burst_done;
    int   n_chk = 0, n_bad = 0, pcnt = 0;
    logic [1:0] div = 0;
    bit   finished = 0;

    scan_clk_ctrl u0 (.fclk(fclk), .tclk(tclk), .sync_clk(sync_clk), .rst_n(rst_n),
        .test_mode(test_mode), .scan_en(scan_en), .sync_mode(sync_mode), .trig(trig),
        .sync_start(sync_start), .clk_out(clk_out), .burst_done(burst_done));

    always #2 fclk = ~fclk;               // 250 MHz
    always @(posedge fclk) begin          // slow related clock, fclk / 4
        div <= div + 1'b1;
        sync_clk <= div[1];
    end
    always @(posedge clk_out) pcnt = pcnt + 1;

    function automatic int exp_burst();
        return 2;                          // pulses per capture window
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tpulse();
        tclk = 1; #20; tclk = 0; #20;
    endtask

    task automatic nedge(int n);
        for (int i = 0; i < n; i++) @(negedge fclk);
    endtask

    // Full shift + capture window, checking counts only (R9, R2, R6, R7).
    task automatic window(bit smode, int nshift, int gap);
        int base;
        @(negedge fclk); sync_mode = smode; scan_en = 1;
        nedge(4);
        pcnt = 0;
        for (int i = 0; i < nshift; i++) tpulse();
        @(negedge fclk);
        check("R2 shift pulses", pcnt, nshift);
        scan_en = 0;
        nedge(4 + gap);
        base = pcnt;
        check("R3 quiet before start", base, nshift);
        if (!smode) begin
            trig = 1; @(negedge fclk); trig = 0;
        end else begin
            sync_start = 1; @(posedge sync_clk); @(negedge fclk);
        end
        nedge(6);
        sync_start = 0;
        check("R9 burst count", pcnt - base, exp_burst());
        check("R7 done set", burst_done, 1);
        trig = 1; sync_start = 1; nedge(12); trig = 0; sync_start = 0;
        check("R6 no rearm", pcnt - base, exp_burst());
        scan_en = 1; nedge(4);
        check("R7 done clear", burst_done, 0);
    endtask

    initial begin
        void'($urandom(32'h5c0c));
        // R5: reset state
        test_mode = 1; trig = 1;
        nedge(12);
        check("R5 no pulse in reset", pcnt, 0);
        check("R5 done low in reset", burst_done, 0);
        trig = 0; scan_en = 1; nedge(2);
        rst_n = 1;
        // R1: functional mode
        test_mode = 0; nedge(2); pcnt = 0; nedge(20);
        check("R1 functional pass", pcnt, 20);
        test_mode = 1; scan_en = 1; nedge(4);
        // R3 and R4: exact timing with trig held from the fall
        pcnt = 0; scan_en = 0; trig = 1;
        nedge(4);
        check("R3 no pulse by edge 4", pcnt, 0);
        nedge(1);
        check("R3 first pulse edge 5", pcnt, 1);
        check("R7 done not yet", burst_done, 0);
        nedge(1);
        check("R4 second pulse", pcnt, 2);
        check("R7 done with second", burst_done, 1);
        trig = 0; nedge(10);
        check("R6 quiet after burst", pcnt, 2);
        // R7 clear timing
        scan_en = 1; nedge(2);
        check("R7 done held 2 edges", burst_done, 1);
        nedge(1);
        check("R7 done clears edge 3", burst_done, 0);
        // R4: single-cycle trigger in local mode
        nedge(2); scan_en = 0; nedge(6); pcnt = 0;
        trig = 1; @(negedge fclk); trig = 0;
        check("R4 none on edge k", pcnt, 0);
        nedge(1); check("R4 pulse k+1", pcnt, 1);
        nedge(1); check("R4 pulse k+2", pcnt, 2);
        nedge(5); check("R4 no third", pcnt, 2);
        scan_en = 1; nedge(6);
        // R8: aligned mode ignores trig, follows strobe
        sync_mode = 1; scan_en = 0; nedge(6); pcnt = 0;
        trig = 1; nedge(8); trig = 0;
        check("R8 trig ignored", pcnt, 0);
        sync_start = 1; @(posedge sync_clk);
        @(negedge fclk); check("R8 none at strobe edge", pcnt, 0);
        nedge(1); check("R8 none next edge", pcnt, 0);
        nedge(1); check("R8 first pulse", pcnt, 1);
        nedge(1); check("R8 second pulse", pcnt, 2);
        sync_start = 0; nedge(8);
        check("R8 no more", pcnt, 2);
        scan_en = 1; nedge(6);
        // R9: random windows
        for (int it = 0; it < 14; it++)
            window(1'($urandom_range(0, 1)), $urandom_range(1, 6), $urandom_range(0, 7));
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule